// File: doc/BRIEF.md
# Programmable Fault Response Sequencer

This block decides, for one power-stage channel, what happens when a fault detector reports trouble. A two-bit mode selects one of three responses. In ignore mode the drive is left alone. In retry mode the drive is cut and restarted after a programmed delay, for as long as the fault keeps returning. In latch mode the drive is cut and stays off. The block owns the gate-drive enable and a one-cycle soft-start request that launches the external ramp. It also keeps a sticky fault status bit.

The retry delay is given in milliseconds and is counted on a 1 ms tick strobe supplied from outside. The value is clamped into a legal window when the wait begins. A latched channel is released only by removing its enable, which is the on/off command and the RUN level taken together. The status bit is cleared by a rising RUN edge, by a rising edge of a partner channel's RUN when sharing is selected, or by a global clear strobe. The fault detectors and the ramp generator sit outside this block.

Top module: `fault_resp_seq`

## Requirements
- R1: While reset is asserted, and after release until the channel is enabled, drive_en_o, ss_start_o and fault_latched_o are all 0.
- R2: The channel is enabled when cmd_on_i and run_i are both 1. When an idle channel becomes enabled, drive_en_o goes to 1 one cycle later. In that same cycle ss_start_o is 1, and only for that one cycle.
- R3: With mode_i = 0 (ignore), a fault has no effect: drive_en_o stays 1, no soft-start is issued and fault_latched_o stays 0.
- R4: With mode_i = 1 (retry), a fault sampled while driving clears drive_en_o and sets fault_latched_o on the next cycle. If fault_i is low when the delay's last tick arrives, the channel restarts with a soft-start pulse; the delay is the clamped program value counted in tick_1ms_i strobes.
- R5: In retry mode, if fault_i is still high when the delay expires, no restart happens and a fresh full delay begins; this repeats without limit.
- R6: The retry delay is clamped when the wait begins: values below 120 count as 120 and values above 83000 count as 83000.
- R7: With mode_i = 2 or 3 (latch), a fault sampled while driving clears drive_en_o and sets fault_latched_o on the next cycle. The channel never restarts on its own, even after the fault goes away.
- R8: A latched channel is released only when the enable drops. Enabling it again then gives a normal start as in R2.
- R9: A rising edge on run_i clears fault_latched_o. A rising edge on peer_run_i clears it only while share_run_clr_i is 1.
- R10: clr_all_i clears fault_latched_o on the next cycle in any state, and leaves the drive state as it is. A new fault event in the same cycle takes priority, and the bit stays set.
- R11: Dropping the enable clears drive_en_o on the next cycle from any state and abandons a retry wait. Re-enabling then starts the channel at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | 1 | Fault level from the detector |
| mode_i | input | 2 | Response: 0 ignore, 1 retry, 2 or 3 latch |
| retry_ms_i | input | RETRY_W | Retry delay in ms before clamping |
| cmd_on_i | input | 1 | Channel on/off command |
| run_i | input | 1 | Channel RUN level |
| peer_run_i | input | 1 | Partner channel RUN level |
| share_run_clr_i | input | 1 | Let partner RUN edges clear this channel's status |
| clr_all_i | input | 1 | Global clear-faults strobe |
| tick_1ms_i | input | 1 | One-cycle strobe each millisecond |
| drive_en_o | output | 1 | Gate-drive enable |
| ss_start_o | output | 1 | One-cycle soft-start request |
| fault_latched_o | output | 1 | Sticky fault status |

## Verification
Every output is a register, so a change on an input shows up at the outputs exactly one clock edge later. The bench drives inputs on the falling edge and reads outputs on the next falling edge. Retry restarts are timed with the tick held high. With a fault pulse sampled at edge 0, the soft-start is due after exactly the clamped delay in edges. With a persistent fault it is due after twice that delay, and the bench counts falling edges from the fault edge against these numbers. Each clear source is checked one cycle after its edge or strobe.

// File: rtl/fr_pkg.sv
package fr_pkg;

  typedef enum logic [1:0] {
    FR_IGNORE   = 2'd0,
    FR_HICCUP   = 2'd1,
    FR_LATCH    = 2'd2,
    FR_LATCH_B  = 2'd3
  } fr_mode_e;

  typedef enum logic [1:0] {
    FR_ST_OFF   = 2'd0,
    FR_ST_RUN   = 2'd1,
    FR_ST_WAIT  = 2'd2,
    FR_ST_LATCH = 2'd3
  } fr_state_e;

  // Bound a programmed delay into the legal window.
  function automatic logic [31:0] fr_clamp(input logic [31:0] v,
                                           input logic [31:0] lo,
                                           input logic [31:0] hi);
    logic [31:0] r;
    r = v;
    if (v < lo) r = lo;
    if (v > hi) r = hi;
    return r;
  endfunction

endpackage

// File: rtl/fr_retry_timer.sv
module fr_retry_timer #(
  parameter int unsigned RETRY_W = 17,
  parameter int unsigned MIN_MS  = 120,
  parameter int unsigned MAX_MS  = 83000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               active_i,
  input  logic               tick_i,
  input  logic [RETRY_W-1:0] retry_ms_i,
  output logic               expire_o
);
  import fr_pkg::*;

  logic [RETRY_W-1:0] cnt_q;
  logic [RETRY_W-1:0] preset;

  assign preset   = RETRY_W'(fr_clamp(32'(retry_ms_i), 32'(MIN_MS), 32'(MAX_MS)));
  assign expire_o = active_i && tick_i && (cnt_q <= RETRY_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= preset;
    end else if (active_i && tick_i) begin
      if (cnt_q <= RETRY_W'(1)) cnt_q <= preset;
      else                      cnt_q <= cnt_q - RETRY_W'(1);
    end
  end

  assert_cnt_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !load_i) |-> (cnt_q >= RETRY_W'(1) && 32'(cnt_q) <= MAX_MS));

endmodule

// File: rtl/fr_clear_ctl.sv
module fr_clear_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic peer_run_i,
  input  logic share_i,
  input  logic clr_all_i,
  output logic clr_o
);
  logic run_q, peer_q;
  logic run_rise, peer_rise;

  assign run_rise  = run_i && !run_q;
  assign peer_rise = peer_i_gate();
  assign clr_o     = clr_all_i || run_rise || peer_rise;

  function automatic logic peer_i_gate();
    return share_i && peer_run_i && !peer_q;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      peer_q <= 1'b0;
    end else begin
      run_q  <= run_i;
      peer_q <= peer_run_i;
    end
  end

  assert_no_peer_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!share_i && !clr_all_i && !run_rise) |-> !clr_o);

endmodule

// File: rtl/fault_resp_seq.sv
module fault_resp_seq #(
  parameter int unsigned RETRY_W = 17,
  parameter int unsigned MIN_MS  = 120,
  parameter int unsigned MAX_MS  = 83000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_i,
  input  logic [1:0]         mode_i,
  input  logic [RETRY_W-1:0] retry_ms_i,
  input  logic               cmd_on_i,
  input  logic               run_i,
  input  logic               peer_run_i,
  input  logic               share_run_clr_i,
  input  logic               clr_all_i,
  input  logic               tick_1ms_i,
  output logic               drive_en_o,
  output logic               ss_start_o,
  output logic               fault_latched_o
);
  import fr_pkg::*;

  fr_state_e state_q, state_d;
  fr_mode_e  mode;
  logic      en;
  logic      set_evt;
  logic      load_evt;
  logic      ss_d;
  logic      timer_done;
  logic      clr_evt;
  logic      waiting;

  assign mode       = fr_mode_e'(mode_i);
  assign en         = cmd_on_i && run_i;
  assign waiting    = (state_q == FR_ST_WAIT);
  assign drive_en_o = (state_q == FR_ST_RUN);

  fr_retry_timer #(
    .RETRY_W (RETRY_W),
    .MIN_MS  (MIN_MS),
    .MAX_MS  (MAX_MS)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_evt),
    .active_i   (waiting),
    .tick_i     (tick_1ms_i),
    .retry_ms_i (retry_ms_i),
    .expire_o   (timer_done)
  );

  fr_clear_ctl u_clear (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .peer_run_i (peer_run_i),
    .share_i    (share_run_clr_i),
    .clr_all_i  (clr_all_i),
    .clr_o      (clr_evt)
  );

  always_comb begin
    state_d  = state_q;
    set_evt  = 1'b0;
    load_evt = 1'b0;
    ss_d     = 1'b0;
    unique case (state_q)
      FR_ST_OFF: begin
        if (en) begin
          state_d = FR_ST_RUN;
          ss_d    = 1'b1;
        end
      end
      FR_ST_RUN: begin
        if (!en) begin
          state_d = FR_ST_OFF;
        end else if (fault_i && mode == FR_HICCUP) begin
          state_d  = FR_ST_WAIT;
          set_evt  = 1'b1;
          load_evt = 1'b1;
        end else if (fault_i && (mode == FR_LATCH || mode == FR_LATCH_B)) begin
          state_d = FR_ST_LATCH;
          set_evt = 1'b1;
        end
      end
      FR_ST_WAIT: begin
        if (!en) begin
          state_d = FR_ST_OFF;
        end else if (timer_done && !fault_i) begin
          state_d = FR_ST_RUN;
          ss_d    = 1'b1;
        end
      end
      FR_ST_LATCH: begin
        if (!en) state_d = FR_ST_OFF;
      end
      default: state_d = FR_ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q         <= FR_ST_OFF;
      ss_start_o      <= 1'b0;
      fault_latched_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      ss_start_o <= ss_d;
      if (set_evt)      fault_latched_o <= 1'b1;
      else if (clr_evt) fault_latched_o <= 1'b0;
    end
  end

  assert_ss_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start_o |=> !ss_start_o);

  assert_ss_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start_o |-> (drive_en_o && !$past(drive_en_o)));

  assert_ignore_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_o && en && mode_i == 2'd0) |=> drive_en_o);

  assert_latch_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_o && en && fault_i && mode_i[1]) |=> (!drive_en_o && fault_latched_o));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all_i && !set_evt) |=> !fault_latched_o);

  assert_enable_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !drive_en_o);

endmodule

// File: tb/fault_resp_seq_bench.sv
module fault_resp_seq_bench;
  localparam int RW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fault = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [RW-1:0] retry = RW'(200);
  logic          cmd_on = 1'b0;
  logic          run = 1'b0;
  logic          peer_run = 1'b0;
  logic          share = 1'b0;
  logic          clr_all = 1'b0;
  logic          tick = 1'b1;
  logic          drive, ss, latched;

  int nchecks = 0;
  int nfail   = 0;
  int ncyc    = 0;

  always #4 clk = ~clk;

  fault_resp_seq u_fault_resp_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .fault_i         (fault),
    .mode_i          (mode),
    .retry_ms_i      (retry),
    .cmd_on_i        (cmd_on),
    .run_i           (run),
    .peer_run_i      (peer_run),
    .share_run_clr_i (share),
    .clr_all_i       (clr_all),
    .tick_1ms_i      (tick),
    .drive_en_o      (drive),
    .ss_start_o      (ss),
    .fault_latched_o (latched)
  );

  // Vector table: mode, programmed delay, expected restart edge (0 = none)
  localparam int NV = 6;
  localparam int V_MODE [NV] = '{0, 2, 1, 1, 1, 3};
  localparam int V_RETRY[NV] = '{200, 200, 5, 120, 200, 150};
  localparam int V_EXP  [NV] = '{0, 0, 120, 120, 200, 0};

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 195000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
      summary();
    end
  end

  // Bring the channel up from idle and verify the start pulse.
  task automatic start_chan(input int m, input int r, input string tag);
    fault = 1'b0; cmd_on = 1'b0; clr_all = 1'b1;
    cyc();
    clr_all = 1'b0; mode = 2'(m); retry = RW'(r); cmd_on = 1'b1; run = 1'b1;
    cyc();
    chk({tag, " R2 drive on start"}, int'(drive), 1);
    chk({tag, " R2 ss pulse"}, int'(ss), 1);
    cyc();
    chk({tag, " R2 ss single"}, int'(ss), 0);
  endtask

  initial begin
    int got;
    cyc();
    chk("R1 reset drive", int'(drive), 0);
    chk("R1 reset ss", int'(ss), 0);
    chk("R1 reset status", int'(latched), 0);
    cyc();
    rst_n = 1'b1;
    cyc(); cyc();
    chk("R1 idle drive", int'(drive), 0);
    chk("R1 idle status", int'(latched), 0);

    for (int i = 0; i < NV; i++) begin
      start_chan(V_MODE[i], V_RETRY[i], "vec");
      fault = 1'b1;
      cyc();
      fault = 1'b0;
      if (V_MODE[i] == 0) begin
        chk("R3 ignore drive", int'(drive), 1);
        chk("R3 ignore status", int'(latched), 0);
      end else begin
        chk("R4 R7 drive cut", int'(drive), 0);
        chk("R4 R7 status set", int'(latched), 1);
      end
      got = 0;
      for (int k = 1; k <= 400; k++) begin
        cyc();
        if (ss && got == 0) got = k;
      end
      if (V_MODE[i] == 1) chk("R4 R6 restart edge", got, V_EXP[i]);
      else                chk("R3 R7 no restart", got, V_EXP[i]);
      chk("R3 R4 R7 final drive", int'(drive), (V_MODE[i] == 2 || V_MODE[i] == 3) ? 0 : 1);
    end

    // R5: persistent fault doubles the wait
    start_chan(1, 130, "R5");
    fault = 1'b1;
    cyc();
    got = 0;
    for (int k = 1; k <= 400; k++) begin
      if (k == 136) fault = 1'b0;
      cyc();
      if (ss && got == 0) got = k;
    end
    chk("R5 restart after two delays", got, 260);

    // R6: upper clamp
    start_chan(1, 100000, "R6");
    fault = 1'b1;
    cyc();
    fault = 1'b0;
    got = 0;
    for (int k = 1; k <= 84000; k++) begin
      cyc();
      if (ss && got == 0) got = k;
    end
    chk("R6 upper clamp", got, 83000);

    // R8: latch released by command off then on
    start_chan(2, 200, "R8");
    fault = 1'b1; cyc(); fault = 1'b0;
    cyc(); cyc();
    chk("R8 latched stays off", int'(drive), 0);
    cmd_on = 1'b0; cyc();
    chk("R8 off drive", int'(drive), 0);
    cmd_on = 1'b1; cyc();
    chk("R8 restart drive", int'(drive), 1);
    chk("R8 restart ss", int'(ss), 1);

    // R10: global clear keeps latch, clears status
    fault = 1'b1; cyc(); fault = 1'b0;
    chk("R10 status set", int'(latched), 1);
    clr_all = 1'b1; cyc(); clr_all = 1'b0;
    chk("R10 clear status", int'(latched), 0);
    chk("R10 drive kept off", int'(drive), 0);

    // R9: peer edge without sharing leaves status, with sharing clears
    cmd_on = 1'b0; cyc(); cmd_on = 1'b1; cyc();
    fault = 1'b1; cyc(); fault = 1'b0;
    peer_run = 1'b1; cyc();
    chk("R9 peer unshared no clear", int'(latched), 1);
    peer_run = 1'b0; share = 1'b1; cyc();
    peer_run = 1'b1; cyc();
    chk("R9 peer shared clear", int'(latched), 0);
    share = 1'b0; peer_run = 1'b0;
    cmd_on = 1'b0; cyc(); cmd_on = 1'b1; cyc();
    fault = 1'b1; cyc(); fault = 1'b0;
    run = 1'b0; cyc();
    chk("R9 status held run low", int'(latched), 1);
    run = 1'b1; cyc();
    chk("R9 run rise clears", int'(latched), 0);
    chk("R9 R8 run restart", int'(ss), 1);

    // R10: set wins over clear in the same cycle
    start_chan(1, 200, "R10");
    fault = 1'b1; clr_all = 1'b1; cyc();
    fault = 1'b0; clr_all = 1'b0;
    chk("R10 set beats clear", int'(latched), 1);

    // R11: drop enable mid-wait, re-enable restarts at once
    cyc();
    cmd_on = 1'b0; cyc();
    chk("R11 drive off", int'(drive), 0);
    cmd_on = 1'b1; cyc();
    chk("R11 immediate restart", int'(ss), 1);
    chk("R11 drive back", int'(drive), 1);

    summary();
  end

endmodule